// File: doc/BRIEF.md
# Cartridge Memory Bank Mapper

This block translates addresses for a cartridge sitting on an 8-bit console bus. The CPU writes a few small registers through a write port, using a 16-bit address and 8 data bits. Those registers then steer three translators that have no clock between input and output.

The first translator turns a CPU address into a program ROM address. Three switchable 8 KB windows sit in front of a fourth window that is hardwired to the last bank. The second translator turns a 13-bit video address into a pattern ROM address. It uses two 4 KB windows, and each window has a 5-bit bank number. The 5 bits come from a 4-bit low part and a single high bit, which are held in separate registers. The third translator folds a name-table address onto a 2 KB internal video RAM, using either vertical or horizontal mirroring.

A synchronous reset clears every register. A register written on one clock edge steers every access made after that edge.

Top module: `cart_bank_xlat`

## Requirements
- R1: A clock edge with `rst` high clears all of the following to zero: the three program bank registers, both pattern low nibbles, both pattern high bits and the mirroring mode.
- R2: The program window is picked by `cpu_addr[15:13]`. Code 100 uses program bank register 0, 101 uses register 1 and 110 uses register 2. Every other address, including all addresses below 0x8000, uses bank 15.
- R3: `prg_rom_addr` equals the selected bank times 0x2000 plus `cpu_addr[12:0]`.
- R4: A strobed write with `wr_addr[15:12]` equal to 0x8 loads `wr_data[3:0]` into program bank register 0. A value of 0xA loads register 1 the same way, and 0xC loads register 2.
- R5: A strobed write with `wr_addr[15:12]` equal to 0x9 does three things at once. Data bit 0 sets the mirroring mode. Data bit 1 sets the high bit of the lower pattern window. Data bit 2 sets the high bit of the upper pattern window.
- R6: A strobed write with `wr_addr[15:12]` equal to 0xE loads `wr_data[3:0]` into the low nibble of the lower pattern window. A value of 0xF loads the upper window's low nibble.
- R7: `vid_addr[12]` picks the window: 0 picks the lower window and 1 picks the upper one. `pat_rom_addr` equals (high bit × 16 + low nibble) × 0x1000 plus `vid_addr[11:0]`.
- R8: In mirroring mode 0 (vertical), `vram_addr` is {`nt_addr[10]`, `nt_addr[9:0]`}. In mode 1 (horizontal), it is {`nt_addr[11]`, `nt_addr[9:0]`}.
- R9: The following writes leave every register unchanged: writes to regions 0xB and 0xD, writes below 0x8000, and any cycle with `wr_en` low.
- R10: A register written on one edge changes the translations from that edge on. Each translation follows its address input with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU read address to translate |
| prg_rom_addr | output | 17 | Program ROM address |
| vid_addr | input | 13 | Video pattern address to translate |
| pat_rom_addr | output | 17 | Pattern ROM address |
| nt_addr | input | 12 | Name-table address to fold |
| vram_addr | output | 11 | Internal video RAM address |

## Verification
The three translations are due in the same cycle as the address that drives them. A register write is due one edge after the cycle in which its strobe is sampled. The driver therefore asserts a write on a falling edge and drops it on the next falling edge. Only after that does it present lookup addresses and queue the expected values. The monitor compares those values shortly after the same falling edge, so that each comparison lands after the write edge and with the lookup inputs stable.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  parameter int CPU_AW     = 16;
  parameter int DATA_W     = 8;
  parameter int PRG_BANK_W = 4;
  parameter int PRG_OFS_W  = 13;
  parameter int PAT_LO_W   = 4;
  parameter int PAT_OFS_W  = 12;
  parameter int NT_OFS_W   = 10;
  parameter int NT_AW      = 12;
  parameter int VID_AW     = PAT_OFS_W + 1;

  localparam int PRG_ROM_W  = PRG_BANK_W + PRG_OFS_W;
  localparam int PAT_BANK_W = PAT_LO_W + 1;
  localparam int PAT_ROM_W  = PAT_BANK_W + PAT_OFS_W;
  localparam int VRAM_W     = NT_OFS_W + 1;

  localparam logic [3:0] RGN_PRG0 = 4'h8;
  localparam logic [3:0] RGN_CTRL = 4'h9;
  localparam logic [3:0] RGN_PRG1 = 4'hA;
  localparam logic [3:0] RGN_PRG2 = 4'hC;
  localparam logic [3:0] RGN_PATL = 4'hE;
  localparam logic [3:0] RGN_PATU = 4'hF;

  localparam logic [PRG_BANK_W-1:0] PRG_FIXED_BANK = '1;

  typedef struct packed {
    logic [PRG_BANK_W-1:0] prg0;
    logic [PRG_BANK_W-1:0] prg1;
    logic [PRG_BANK_W-1:0] prg2;
    logic [PAT_LO_W-1:0]   pat_lo_l;
    logic [PAT_LO_W-1:0]   pat_lo_u;
    logic                  pat_hi_l;
    logic                  pat_hi_u;
    logic                  mirror_h;
  } bank_regs_t;

  function automatic logic [PRG_ROM_W-1:0] prg_join(
      input logic [PRG_BANK_W-1:0] bank, input logic [CPU_AW-1:0] a);
    return {bank, a[PRG_OFS_W-1:0]};
  endfunction

  function automatic logic [PAT_ROM_W-1:0] pat_join(
      input logic hi, input logic [PAT_LO_W-1:0] lo, input logic [VID_AW-1:0] a);
    return {hi, lo, a[PAT_OFS_W-1:0]};
  endfunction

  function automatic logic [VRAM_W-1:0] nt_fold(
      input logic horiz, input logic [NT_AW-1:0] a);
    return {(horiz ? a[NT_OFS_W+1] : a[NT_OFS_W]), a[NT_OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/cbx_regfile.sv
module cbx_regfile
  import cbx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CPU_AW-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output bank_regs_t          regs
);
  logic [3:0] rgn;
  logic hit_prg0, hit_prg1, hit_prg2, hit_ctrl, hit_patl, hit_patu, wr_hit_any;
  logic [DATA_W-1:0] unused_wr_data;
  bank_regs_t regs_q;

  assign rgn      = wr_addr[CPU_AW-1 -: 4];
  assign hit_prg0 = wr_en && (rgn == RGN_PRG0);
  assign hit_prg1 = wr_en && (rgn == RGN_PRG1);
  assign hit_prg2 = wr_en && (rgn == RGN_PRG2);
  assign hit_ctrl = wr_en && (rgn == RGN_CTRL);
  assign hit_patl = wr_en && (rgn == RGN_PATL);
  assign hit_patu = wr_en && (rgn == RGN_PATU);
  assign wr_hit_any = hit_prg0 | hit_prg1 | hit_prg2 | hit_ctrl | hit_patl | hit_patu;
  assign unused_wr_data = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else begin
      if (hit_prg0) regs_q.prg0     <= wr_data[PRG_BANK_W-1:0];
      if (hit_prg1) regs_q.prg1     <= wr_data[PRG_BANK_W-1:0];
      if (hit_prg2) regs_q.prg2     <= wr_data[PRG_BANK_W-1:0];
      if (hit_patl) regs_q.pat_lo_l <= wr_data[PAT_LO_W-1:0];
      if (hit_patu) regs_q.pat_lo_u <= wr_data[PAT_LO_W-1:0];
      if (hit_ctrl) begin
        regs_q.mirror_h <= wr_data[0];
        regs_q.pat_hi_l <= wr_data[1];
        regs_q.pat_hi_u <= wr_data[2];
      end
    end
  end

  assign regs = regs_q;

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_q == '0));
  // R4
  prg0_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit_prg0 |=> (regs_q.prg0 == $past(wr_data[PRG_BANK_W-1:0])));
  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ctrl |=> ({regs_q.pat_hi_u, regs_q.pat_hi_l, regs_q.mirror_h} == $past(wr_data[2:0])));
  // R6
  patu_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit_patu |=> (regs_q.pat_lo_u == $past(wr_data[PAT_LO_W-1:0])));
  // R9
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit_any |=> $stable(regs_q));
endmodule

// File: rtl/cbx_prg_xlat.sv
module cbx_prg_xlat
  import cbx_pkg::*;
(
  input  bank_regs_t             regs,
  input  logic [CPU_AW-1:0]      cpu_addr,
  output logic [PRG_ROM_W-1:0]   prg_rom_addr
);
  logic [PRG_BANK_W-1:0] bank_sel;
  logic [PAT_LO_W*2+2:0] unused_pat;

  assign unused_pat = {regs.pat_lo_l, regs.pat_lo_u, regs.pat_hi_l, regs.pat_hi_u, regs.mirror_h};

  always_comb begin
    case (cpu_addr[CPU_AW-1 -: 3])
      3'b100:  bank_sel = regs.prg0;
      3'b101:  bank_sel = regs.prg1;
      3'b110:  bank_sel = regs.prg2;
      default: bank_sel = PRG_FIXED_BANK;
    endcase
  end

  assign prg_rom_addr = prg_join(bank_sel, cpu_addr);
endmodule

// File: rtl/cbx_pat_xlat.sv
module cbx_pat_xlat
  import cbx_pkg::*;
(
  input  bank_regs_t             regs,
  input  logic [VID_AW-1:0]      vid_addr,
  output logic [PAT_ROM_W-1:0]   pat_rom_addr
);
  logic upper;
  logic [PRG_BANK_W*3:0] unused_prg;

  assign unused_prg = {regs.prg0, regs.prg1, regs.prg2, regs.mirror_h};
  assign upper = vid_addr[PAT_OFS_W];
  assign pat_rom_addr = upper ? pat_join(regs.pat_hi_u, regs.pat_lo_u, vid_addr)
                              : pat_join(regs.pat_hi_l, regs.pat_lo_l, vid_addr);
endmodule

// File: rtl/cbx_nt_xlat.sv
module cbx_nt_xlat
  import cbx_pkg::*;
(
  input  bank_regs_t          regs,
  input  logic [NT_AW-1:0]    nt_addr,
  output logic [VRAM_W-1:0]   vram_addr
);
  logic [PRG_BANK_W*3+PAT_LO_W*2+1:0] unused_rest;

  assign unused_rest = {regs.prg0, regs.prg1, regs.prg2, regs.pat_lo_l,
                        regs.pat_lo_u, regs.pat_hi_l, regs.pat_hi_u};
  assign vram_addr = nt_fold(regs.mirror_h, nt_addr);
endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
  import cbx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CPU_AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [CPU_AW-1:0]     cpu_addr,
  output logic [PRG_ROM_W-1:0]  prg_rom_addr,
  input  logic [VID_AW-1:0]     vid_addr,
  output logic [PAT_ROM_W-1:0]  pat_rom_addr,
  input  logic [NT_AW-1:0]      nt_addr,
  output logic [VRAM_W-1:0]     vram_addr
);
  bank_regs_t regs;

  cbx_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs)
  );
  cbx_prg_xlat u_prg (.regs(regs), .cpu_addr(cpu_addr), .prg_rom_addr(prg_rom_addr));
  cbx_pat_xlat u_pat (.regs(regs), .vid_addr(vid_addr), .pat_rom_addr(pat_rom_addr));
  cbx_nt_xlat  u_nt  (.regs(regs), .nt_addr(nt_addr), .vram_addr(vram_addr));

  // R2
  fixed_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_addr[CPU_AW-1] || (cpu_addr[CPU_AW-2 -: 2] == 2'b11))
      |-> (prg_rom_addr[PRG_ROM_W-1 -: PRG_BANK_W] == PRG_FIXED_BANK));
  // R3
  prg_offset_chk: assert property (@(posedge clk) disable iff (rst)
    prg_rom_addr[PRG_OFS_W-1:0] == cpu_addr[PRG_OFS_W-1:0]);
  // R7
  pat_offset_chk: assert property (@(posedge clk) disable iff (rst)
    pat_rom_addr[PAT_OFS_W-1:0] == vid_addr[PAT_OFS_W-1:0]);
  // R8
  nt_low_chk: assert property (@(posedge clk) disable iff (rst)
    vram_addr[NT_OFS_W-1:0] == nt_addr[NT_OFS_W-1:0]);
endmodule

// File: tb/cart_bank_xlat_tb.sv
module cart_bank_xlat_tb;
  logic clk = 1'b0;
  logic rst, wr_en;
  logic [15:0] wr_addr, cpu_addr;
  logic [7:0]  wr_data;
  logic [12:0] vid_addr;
  logic [11:0] nt_addr;
  logic [16:0] prg_rom_addr, pat_rom_addr;
  logic [10:0] vram_addr;

  always #2.5 clk = ~clk;

  cart_bank_xlat u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .prg_rom_addr(prg_rom_addr), .vid_addr(vid_addr),
    .pat_rom_addr(pat_rom_addr), .nt_addr(nt_addr), .vram_addr(vram_addr)
  );

  typedef struct {
    string       req;
    int          kind;   // 0 program, 1 pattern, 2 vram
    logic [16:0] exp;
  } item_t;

  item_t sbq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_prg[3];
  int m_lo[2];
  int m_hi[2];
  int m_mir;

  function automatic int exp_prg(int a);
    int b;
    b = 15;
    if (a >= 'h8000 && a < 'hA000) b = m_prg[0];
    else if (a >= 'hA000 && a < 'hC000) b = m_prg[1];
    else if (a >= 'hC000 && a < 'hE000) b = m_prg[2];
    return b * 'h2000 + (a % 'h2000);
  endfunction

  function automatic int exp_pat(int a);
    int w;
    w = (a / 'h1000) % 2;
    return (m_hi[w] * 16 + m_lo[w]) * 'h1000 + (a % 'h1000);
  endfunction

  function automatic int exp_nt(int a);
    int top;
    top = (m_mir != 0) ? (a / 'h800) % 2 : (a / 'h400) % 2;
    return top * 'h400 + (a % 'h400);
  endfunction

  task automatic model_reset();
    foreach (m_prg[i]) m_prg[i] = 0;
    foreach (m_lo[i]) m_lo[i] = 0;
    foreach (m_hi[i]) m_hi[i] = 0;
    m_mir = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic do_write(input int a, input int d, input bit strobe);
    @(negedge clk);
    wr_en = strobe; wr_addr = a[15:0]; wr_data = d[7:0];
    if (strobe) begin
      case (a / 'h1000)
        'h8: m_prg[0] = d % 16;
        'hA: m_prg[1] = d % 16;
        'hC: m_prg[2] = d % 16;
        'hE: m_lo[0]  = d % 16;
        'hF: m_lo[1]  = d % 16;
        'h9: begin m_mir = d % 2; m_hi[0] = (d / 2) % 2; m_hi[1] = (d / 4) % 2; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input string req, input int ca, input int va, input int na);
    item_t it;
    @(negedge clk);
    cpu_addr = ca[15:0]; vid_addr = va[12:0]; nt_addr = na[11:0];
    it.req = req; it.kind = 0; it.exp = 17'(exp_prg(ca)); sbq.push_back(it);
    it.kind = 1; it.exp = 17'(exp_pat(va)); sbq.push_back(it);
    it.kind = 2; it.exp = 17'(exp_nt(na)); sbq.push_back(it);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        logic [16:0] act;
        it = sbq.pop_front();
        act = (it.kind == 0) ? prg_rom_addr :
              (it.kind == 1) ? pat_rom_addr : {6'd0, vram_addr};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cpu_addr = '0; vid_addr = '0; nt_addr = '0;
    model_reset();
    do_reset();
    // R1 reset state
    probe("R1", 'h8123, 'h0456, 'h0400);
    probe("R1", 'hC001, 'h1FFF, 'h0BFF);
    // R4 loads with upper data bits masked
    do_write('h8000, 'hF5, 1);
    do_write('hA7FF, 'h0A, 1);
    do_write('hC000, 'h03, 1);
    // R10 register written last edge already steers this access
    probe("R10", 'h8000, 'h0000, 'h0000);
    // R2 / R3 window decode and offsets
    probe("R2", 'h9FFF, 'h0001, 'h0001);
    probe("R3", 'hA123, 'h0002, 'h0002);
    probe("R3", 'hDFFF, 'h0003, 'h0003);
    probe("R2", 'hE000, 'h0004, 'h0004);
    probe("R2", 'hFFFF, 'h0005, 'h0005);
    probe("R2", 'h1234, 'h0006, 'h0006);
    // R6 / R5 / R7 pattern banks
    do_write('hE000, 'h07, 1);
    do_write('hF000, 'h1C, 1);
    probe("R6", 'h8000, 'h0ABC, 'h0000);
    probe("R6", 'h8000, 'h1ABC, 'h0000);
    do_write('h9000, 'h06, 1);
    probe("R7", 'h8000, 'h0ABC, 'h0C05);
    probe("R7", 'h8000, 'h1ABC, 'h0805);
    do_write('h9000, 'h02, 1);
    probe("R5", 'h8000, 'h1ABC, 'h0405);
    // R8 mirroring
    probe("R8", 'h8000, 'h0000, 'h0C05);
    probe("R8", 'h8000, 'h0000, 'h0805);
    do_write('h9FFF, 'h01, 1);
    probe("R8", 'h8000, 'h0FFF, 'h0C05);
    probe("R8", 'h8000, 'h1FFF, 'h0805);
    probe("R8", 'h8000, 'h0000, 'h0405);
    // R9 writes that must not change anything
    do_write('hB000, 'h0F, 1);
    do_write('hD000, 'h0F, 1);
    do_write('h7000, 'h0F, 1);
    do_write('h0000, 'h0F, 1);
    do_write('h8000, 'h0C, 0);
    do_write('h9000, 'h00, 0);
    do_write('hE000, 'h00, 0);
    probe("R9", 'h8000, 'h0123, 'h0C05);
    probe("R9", 'hB000, 'h1123, 'h0405);
    probe("R9", 'hD000, 'h0000, 'h0000);
    // R1 reset from non-zero state
    do_reset();
    probe("R1", 'h8000, 'h1ABC, 'h0805);
    probe("R1", 'hA000, 'h0ABC, 'h0C05);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule